// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block decides which interrupt a small CPU core should take next. It serves a set of maskable request lines and three special sources. Each maskable line carries a two-bit software level that software programs through a write port. Its position in the request vector gives it a fixed rank, and that rank breaks ties between lines at the same level. The three special sources are reset, a software trap and a high-priority pin interrupt. The controller compares the pending work against the CPU's current mask level and presents a registered grant. The grant carries a vector number and the level the CPU will run at once it accepts.

When the CPU acknowledges a grant, the controller pushes the running level onto a small stack and raises the mask to the granted level. A return-from-interrupt pops the stack again. Reset is the controller's own synchronous reset. While reset is low, no grant is shown. Vector 0 is reserved for reset and is never presented as a grant. Requests are level-sensitive and stay pending until the CPU takes them. Edge detection, vector fetch and context saving belong to neighbouring logic.

Top module: `nest_irq_ctrl`

## Requirements
- R1: While and after reset, `irq_valid` is 0, `cur_level` is 3 and every source level is 3, so no maskable request is granted until software lowers the mask; once lowered, a source reports level 3.
- R2: A write with `cfg_we` sets the level of source `cfg_idx` to `cfg_level`; a write whose index is at or above the number of sources changes no source.
- R3: A maskable request is granted only if its level is strictly above `cur_level`; a level-0 source is therefore never granted.
- R4: Among eligible maskable requests, the one with the highest level is granted.
- R5: Among eligible requests of equal level, the lowest source index wins.
- R6: Vectors are fixed: trap is 1, the pin interrupt is 2, source i is i+3. A grant appears on `irq_valid` one clock after the request is seen. `irq_level` carries the source's level, or 3 for trap and the pin interrupt.
- R7: `cpu_ack` while `irq_valid` is 1 pushes the running level, sets `cur_level` to `irq_level` on the next edge, and clears `irq_valid` for the following cycle.
- R8: `cpu_rti` restores the level saved by the matching acknowledge; with an empty stack it changes nothing.
- R9: Trap ignores the mask and outranks every maskable request. It is not granted while a level-3 handler is running, meaning at least one frame is stacked and `cur_level` is 3.
- R10: The pin interrupt ignores the mask and outranks trap and all maskable requests. It preempts a running level-3 handler, but it is not granted while its own handler runs.
- R11: When the stack holds its full depth of 4 frames, no grant of any kind is made until a return frees a slot.
- R12: `mask_we` loads `cur_level` from `mask_level`, except in a cycle where an acknowledged grant or a popping return also updates the level; those take precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | NUM_SRC | Level-sensitive maskable requests, bit 0 ranks highest |
| trap_req | input | 1 | Software trap request |
| hipin_req | input | 1 | High-priority pin interrupt request |
| cfg_we | input | 1 | Source level write strobe |
| cfg_idx | input | IDX_W | Source index for the level write |
| cfg_level | input | 2 | Level value to write |
| mask_we | input | 1 | Mask level write strobe |
| mask_level | input | 2 | New mask level |
| cpu_ack | input | 1 | CPU takes the presented grant |
| cpu_rti | input | 1 | CPU returns from a handler |
| irq_valid | output | 1 | A grant is presented |
| irq_vector | output | VEC_W | Vector number of the grant |
| irq_level | output | 2 | Level the CPU runs at after acknowledging |
| cur_level | output | 2 | Current mask level |

## Verification
The bench keeps the default build of 29 maskable sources and a stack depth of 4. With those values, the last source maps to vector 31 and fills the 5-bit vector field exactly. The default depth can be filled with four level-1 handlers, because the mask is lowered after each acknowledge. This shows that a full stack blocks a request that would otherwise win, including a trap. It also lets the bench check an out-of-range index write, because a 5-bit index can name slots 29 to 31, where no source exists.

// File: rtl/nic_pkg.sv
// Shared types and fixed vector numbering for the nested interrupt controller.
// Assumes levels are two bits wide; level 3 is the non-interruptible level.
package nic_pkg;
    localparam int LVL_W = 2;
    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_MAX = 2'd3;

    // Vector 0 is reserved for reset and never presented as a grant.
    localparam int VEC_TRAP = 1;
    localparam int VEC_PIN  = 2;
    localparam int VEC_BASE = 3;

    // One saved context on the nesting stack.
    typedef struct packed {
        lvl_t level;
        logic pin;
    } frame_t;
endpackage

// File: rtl/nic_level_regs.sv
// Per-source software level registers.
// Each source owns a two-bit level that resets to the maximum level.
// Writes with an index at or above NUM_SRC match no source and are dropped.
module nic_level_regs
    import nic_pkg::*;
#(
    parameter int NUM_SRC = 29,
    parameter int IDX_W   = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [IDX_W-1:0]          cfg_idx,
    input  lvl_t                      cfg_level,
    output logic [NUM_SRC-1:0][LVL_W-1:0] src_level
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SRC - 1);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
        lvl_t lvl_q;

        // Hold this source's level; load it when the write index matches.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_q <= LVL_MAX;
            end else if (cfg_we && (cfg_idx == MY_IDX)) begin
                lvl_q <= cfg_level;
            end
        end

        assign src_level[i] = lvl_q;
    end

    // An in-range write lands in the addressed source on the next edge.
    assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_idx <= LAST_IDX)) |=> (src_level[$past(cfg_idx)] == $past(cfg_level)));
endmodule

// File: rtl/nic_arbiter.sv
// Two-stage maskable arbitration, purely combinational.
// Stage one picks the highest programmed level strictly above the current mask.
// Stage two picks the lowest index among the requests at that level.
// Level 0 is never above any mask, so it has no request vector.
module nic_arbiter
    import nic_pkg::*;
#(
    parameter int NUM_SRC = 29,
    parameter int IDX_W   = 5
) (
    input  logic [NUM_SRC-1:0]            req,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] src_level,
    input  lvl_t                          cur_level,
    output logic                          win_valid,
    output logic [IDX_W-1:0]              win_idx,
    output lvl_t                          win_level
);
    logic [NUM_SRC-1:0] hit [1:3];
    logic [NUM_SRC-1:0] sel;

    for (genvar l = 1; l < 4; l++) begin : g_lvl
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
            assign hit[l][i] = req[i] && (src_level[i] == lvl_t'(l));
        end
    end

    // Stage one: the highest level with any request above the mask.
    always_comb begin
        win_valid = 1'b0;
        win_level = '0;
        sel       = '0;
        for (int l = 1; l < 4; l++) begin
            if ((|hit[l]) && (lvl_t'(l) > cur_level)) begin
                win_valid = 1'b1;
                win_level = lvl_t'(l);
                sel       = hit[l];
            end
        end
    end

    // Stage two: the lowest index set in the chosen level's vector.
    always_comb begin
        win_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (sel[i]) win_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/nic_level_stack.sv
// Current mask level plus a stack of saved contexts.
// A push saves the running level and pin flag, then loads the new context.
// A pop restores the newest saved context; a pop on an empty stack is dropped.
// Priority order: push, then pop, then a direct mask write.
// Assumes DEPTH is a power of two.
module nic_level_stack
    import nic_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  lvl_t push_level,
    input  logic push_pin,
    input  logic pop,
    input  logic mask_we,
    input  lvl_t mask_level,
    output lvl_t cur_level,
    output logic in_pin,
    output logic nested,
    output logic full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    frame_t           stk [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_m1;
    lvl_t             cur_q;
    logic             pin_q;

    assign cnt_m1    = cnt_q - 1'b1;
    assign full      = (cnt_q == FULL_CNT);
    assign nested    = (cnt_q != '0);
    assign cur_level = cur_q;
    assign in_pin    = pin_q;

    // Update the running context and the stack depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= LVL_MAX;
            pin_q <= 1'b0;
            cnt_q <= '0;
        end else if (push && !full) begin
            cur_q <= push_level;
            pin_q <= push_pin;
            cnt_q <= cnt_q + 1'b1;
        end else if (pop && nested) begin
            cur_q <= stk[cnt_m1[PTR_W-1:0]].level;
            pin_q <= stk[cnt_m1[PTR_W-1:0]].pin;
            cnt_q <= cnt_m1;
        end else if (mask_we) begin
            cur_q <= mask_level;
        end
    end

    // Save the running context into the next free slot on a push.
    always_ff @(posedge clk) begin
        if (push && !full) begin
            stk[cnt_q[PTR_W-1:0]] <= '{level: cur_q, pin: pin_q};
        end
    end

    assert_depth_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);

    assert_push_depth_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> (cnt_q == $past(cnt_q) + 1'b1));

    assert_empty_rti_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !nested && !push && !mask_we) |=> $stable(cur_level));
endmodule

// File: rtl/nest_irq_ctrl.sv
// Nested priority interrupt controller top.
// Picks among the pin interrupt, the trap and the maskable winner, in that order.
// The grant is registered, so it appears one cycle after the request.
// An acknowledge pushes the context and drops the grant for one cycle.
// Assumes the CPU acknowledges only while irq_valid is high.
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int  NUM_SRC     = 29,
    parameter int  STACK_DEPTH = 4,
    localparam int IDX_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int VEC_W       = $clog2(NUM_SRC + VEC_BASE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               trap_req,
    input  logic               hipin_req,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [1:0]         cfg_level,
    input  logic               mask_we,
    input  logic [1:0]         mask_level,
    input  logic               cpu_ack,
    input  logic               cpu_rti,
    output logic               irq_valid,
    output logic [VEC_W-1:0]   irq_vector,
    output logic [1:0]         irq_level,
    output logic [1:0]         cur_level
);
    localparam logic [VEC_W-1:0] V_TRAP = VEC_W'(VEC_TRAP);
    localparam logic [VEC_W-1:0] V_PIN  = VEC_W'(VEC_PIN);
    localparam logic [VEC_W-1:0] V_BASE = VEC_W'(VEC_BASE);

    logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl;
    lvl_t             run_lvl;
    logic             in_pin, nested, stk_full;
    logic             arb_valid;
    logic [IDX_W-1:0] arb_idx;
    lvl_t             arb_lvl;
    logic             nxt_valid, nxt_pin;
    logic [VEC_W-1:0] nxt_vec;
    lvl_t             nxt_lvl;
    logic             grant_pin_q;
    logic             lvl3_busy;
    logic             take;

    nic_level_regs #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) lvl_regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_level (cfg_level),
        .src_level (src_lvl)
    );

    nic_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) arb_i (
        .req       (src_req),
        .src_level (src_lvl),
        .cur_level (run_lvl),
        .win_valid (arb_valid),
        .win_idx   (arb_idx),
        .win_level (arb_lvl)
    );

    assign take = cpu_ack && irq_valid;

    nic_level_stack #(.DEPTH(STACK_DEPTH)) stack_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (take),
        .push_level (irq_level),
        .push_pin   (grant_pin_q),
        .pop        (cpu_rti),
        .mask_we    (mask_we),
        .mask_level (mask_level),
        .cur_level  (run_lvl),
        .in_pin     (in_pin),
        .nested     (nested),
        .full       (stk_full)
    );

    assign cur_level = run_lvl;
    assign lvl3_busy = nested && (run_lvl == LVL_MAX);

    // Choose the next grant: pin interrupt, then trap, then the maskable winner.
    always_comb begin
        nxt_valid = 1'b0;
        nxt_pin   = 1'b0;
        nxt_vec   = '0;
        nxt_lvl   = '0;
        if (!stk_full) begin
            if (hipin_req && !in_pin) begin
                nxt_valid = 1'b1;
                nxt_pin   = 1'b1;
                nxt_vec   = V_PIN;
                nxt_lvl   = LVL_MAX;
            end else if (trap_req && !lvl3_busy) begin
                nxt_valid = 1'b1;
                nxt_vec   = V_TRAP;
                nxt_lvl   = LVL_MAX;
            end else if (arb_valid) begin
                nxt_valid = 1'b1;
                nxt_vec   = VEC_W'(arb_idx) + V_BASE;
                nxt_lvl   = arb_lvl;
            end
        end
    end

    // Register the grant; an acknowledge drops it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || cpu_ack) begin
            irq_valid   <= 1'b0;
            irq_vector  <= '0;
            irq_level   <= '0;
            grant_pin_q <= 1'b0;
        end else begin
            irq_valid   <= nxt_valid;
            irq_vector  <= nxt_vec;
            irq_level   <= nxt_lvl;
            grant_pin_q <= nxt_pin;
        end
    end

    assert_mask_strict_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && (irq_vector >= V_BASE)) |-> (irq_level > $past(run_lvl)));

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !irq_valid);

    assert_trap_lvl3_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && (irq_vector == V_TRAP)) |-> !$past(lvl3_busy));

    assert_pin_no_reenter_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && (irq_vector == V_PIN)) |-> !$past(in_pin));

    assert_full_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !$past(stk_full));
endmodule

// File: tb/nest_irq_ctrl_tb.sv
`timescale 1ns/1ps
module nest_irq_ctrl_tb_top;
    localparam int NSRC = 29;
    localparam int IW   = 5;
    localparam int VW   = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_req = '0;
    logic            trap_req = 1'b0, hipin_req = 1'b0;
    logic            cfg_we = 1'b0;
    logic [IW-1:0]   cfg_idx = '0;
    logic [1:0]      cfg_level = '0;
    logic            mask_we = 1'b0;
    logic [1:0]      mask_level = '0;
    logic            cpu_ack = 1'b0, cpu_rti = 1'b0;
    logic            irq_valid;
    logic [VW-1:0]   irq_vector;
    logic [1:0]      irq_level, cur_level;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    nest_irq_ctrl #(.NUM_SRC(NSRC), .STACK_DEPTH(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .trap_req(trap_req),
        .hipin_req(hipin_req), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_level(cfg_level), .mask_we(mask_we), .mask_level(mask_level),
        .cpu_ack(cpu_ack), .cpu_rti(cpu_rti), .irq_valid(irq_valid),
        .irq_vector(irq_vector), .irq_level(irq_level), .cur_level(cur_level)
    );

    task automatic step(int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_grant(string tag, int v, int lvl);
        chk({tag, " valid"}, int'(irq_valid), 1);
        if (irq_valid) begin
            chk({tag, " vector"}, int'(irq_vector), v);
            chk({tag, " level"}, int'(irq_level), lvl);
        end
    endtask

    task automatic do_reset();
        src_req = '0; trap_req = 0; hipin_req = 0; cfg_we = 0;
        mask_we = 0; cpu_ack = 0; cpu_rti = 0;
        rst_n = 0;
        step(2);
        rst_n = 1;
        step(1);
    endtask

    task automatic set_lvl(int idx, int lvl);
        cfg_we = 1; cfg_idx = IW'(idx); cfg_level = 2'(lvl);
        step(1);
        cfg_we = 0;
    endtask

    task automatic set_mask(int lvl);
        mask_we = 1; mask_level = 2'(lvl);
        step(1);
        mask_we = 0;
    endtask

    task automatic ack();
        cpu_ack = 1;
        step(1);
        cpu_ack = 0;
    endtask

    task automatic rti();
        cpu_rti = 1;
        step(1);
        cpu_rti = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 valid after reset", int'(irq_valid), 0);
        chk("R1 mask after reset", int'(cur_level), 3);
        src_req[5] = 1;
        step(2);
        chk("R1 blocked at mask 3", int'(irq_valid), 0);
        set_mask(0);
        step(1);
        chk_grant("R1 default level", 8, 3);
        src_req = '0;
    endtask

    task automatic t_cfg();
        do_reset();
        set_mask(0);
        set_lvl(4, 1);
        set_lvl(31, 0);
        src_req[4] = 1;
        step(2);
        chk_grant("R2 written level", 7, 1);
        src_req = '0; src_req[28] = 1;
        step(2);
        chk_grant("R2 out-of-range write dropped", 31, 3);
        src_req = '0;
    endtask

    task automatic t_strict();
        do_reset();
        set_mask(1);
        set_lvl(2, 1);
        src_req[2] = 1;
        step(2);
        chk("R3 equal level blocked", int'(irq_valid), 0);
        set_lvl(2, 2);
        step(2);
        chk_grant("R3 above mask granted", 5, 2);
        set_lvl(2, 0);
        set_mask(0);
        step(2);
        chk("R3 level 0 never granted", int'(irq_valid), 0);
        src_req = '0;
    endtask

    task automatic t_order();
        do_reset();
        set_mask(0);
        set_lvl(1, 1);
        set_lvl(20, 2);
        src_req[1] = 1; src_req[20] = 1;
        step(2);
        chk_grant("R4 higher level wins", 23, 2);
        src_req = '0;
        set_lvl(3, 2);
        set_lvl(10, 2);
        src_req[10] = 1; src_req[3] = 1;
        step(2);
        chk_grant("R5 lower index wins", 6, 2);
        src_req = '0; src_req[28] = 1; src_req[0] = 1;
        step(2);
        chk_grant("R5 index 0 over 28", 3, 3);
        src_req = '0;
    endtask

    task automatic t_latency();
        do_reset();
        set_mask(0);
        step(1);
        src_req[9] = 1;
        #1;
        chk("R6 not yet valid", int'(irq_valid), 0);
        step(1);
        chk_grant("R6 one cycle later", 12, 3);
        src_req = '0;
    endtask

    task automatic t_nest();
        do_reset();
        set_mask(0);
        set_lvl(6, 1); set_lvl(7, 1); set_lvl(8, 2);
        src_req[6] = 1;
        step(2);
        chk_grant("R7 first grant", 9, 1);
        src_req[6] = 0;
        ack();
        chk("R7 mask raised", int'(cur_level), 1);
        chk("R7 valid dropped", int'(irq_valid), 0);
        src_req[7] = 1;
        step(2);
        chk("R3 same level no preempt", int'(irq_valid), 0);
        src_req[7] = 0; src_req[8] = 1;
        step(2);
        chk_grant("R7 nested grant", 11, 2);
        src_req[8] = 0;
        ack();
        chk("R7 mask raised again", int'(cur_level), 2);
        rti();
        chk("R8 pop to 1", int'(cur_level), 1);
        rti();
        chk("R8 pop to 0", int'(cur_level), 0);
        rti();
        chk("R8 empty pop ignored", int'(cur_level), 0);
    endtask

    task automatic t_trap();
        do_reset();
        trap_req = 1;
        step(2);
        chk_grant("R9 trap ignores mask", 1, 3);
        set_mask(0);
        src_req[0] = 1;
        step(2);
        chk_grant("R9 trap over maskable", 1, 3);
        trap_req = 0;
        ack();
        chk("R9 trap handler level", int'(cur_level), 3);
        trap_req = 1;
        step(2);
        chk("R9 no trap in level-3 handler", int'(irq_valid), 0);
        trap_req = 0; src_req = '0;
        rti();
        chk("R8 back to 0", int'(cur_level), 0);
    endtask

    task automatic t_pin();
        do_reset();
        hipin_req = 1; trap_req = 1;
        step(2);
        chk_grant("R10 pin over trap", 2, 3);
        hipin_req = 0;
        ack();
        hipin_req = 1;
        step(2);
        chk("R10 no pin or trap in pin handler", int'(irq_valid), 0);
        hipin_req = 0; trap_req = 0;
        rti();
        set_mask(0);
        src_req[0] = 1;
        step(2);
        src_req[0] = 0;
        ack();
        hipin_req = 1;
        step(2);
        chk_grant("R10 pin preempts level 3", 2, 3);
        hipin_req = 0;
        ack();
        rti();
        rti();
        chk("R8 unwound", int'(cur_level), 0);
    endtask

    task automatic t_full();
        do_reset();
        set_mask(0);
        for (int k = 0; k < 5; k++) set_lvl(k, 1);
        for (int k = 0; k < 4; k++) begin
            src_req[k] = 1;
            step(2);
            chk_grant("R11 fill grant", k + 3, 1);
            src_req[k] = 0;
            ack();
            set_mask(0);
        end
        src_req[4] = 1; trap_req = 1;
        step(2);
        chk("R11 full blocks", int'(irq_valid), 0);
        rti();
        step(1);
        chk_grant("R11 slot freed, trap wins", 1, 3);
        src_req = '0; trap_req = 0;
    endtask

    task automatic t_maskwr();
        do_reset();
        set_mask(0);
        set_lvl(5, 2);
        src_req[5] = 1;
        step(2);
        src_req[5] = 0;
        cpu_ack = 1; mask_we = 1; mask_level = 2'd1;
        step(1);
        cpu_ack = 0; mask_we = 0;
        chk("R12 ack beats mask write", int'(cur_level), 2);
        cpu_rti = 1; mask_we = 1; mask_level = 2'd1;
        step(1);
        cpu_rti = 0; mask_we = 0;
        chk("R12 pop beats mask write", int'(cur_level), 0);
        set_mask(2);
        chk("R12 plain mask write", int'(cur_level), 2);
    endtask

    initial begin
        t_reset();
        t_cfg();
        t_strict();
        t_order();
        t_latency();
        t_nest();
        t_trap();
        t_pin();
        t_full();
        t_maskwr();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all-R actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule